// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences a processor subsystem between full operation and three reduced-power states. A light sleep stops only the core clock. A deep sleep stops every clock in the core domain and turns off the internal RC oscillator, the crystal oscillator and the PLL. A standby state can be left only through reset. Entry is triggered in one of two ways: by a wait-for-interrupt or wait-for-event pulse, or, when the sleep-on-exit control is set, by the indication that the core has returned from its lowest-priority handler.

How the block wakes depends on how it went to sleep. An entry by wait-for-interrupt wakes on an interrupt. An entry by wait-for-event wakes on an event, and also on an interrupt when the send-event-on-pending control is set. In deep sleep only the external-line interrupt and event inputs count as wake sources. Leaving deep sleep emits a one-cycle request to switch the system clock to the internal RC oscillator. If the regulator low-power control was set when deep sleep was entered, that exit first waits a parameterised number of cycles.

The block also holds the regulator voltage selection. A write to it is accepted only while the PLL is off. The stored setting reaches the output only while the PLL is locked; while the PLL is not locked, the output carries a fixed low-voltage code.

Top module: `lpm_ctrl`

## Requirements
- R1: With the deep control clear and sleep-on-exit clear, a wfi_p or wfe_p pulse moves mode (00 run, 01 sleep, 10 deep, 11 standby) from 00 to 01 on the next cycle. In sleep, core_clk_en is 0 and domain_clk_en stays 1.
- R2: With sleep-on-exit set, wfi_p and wfe_p cause no entry. A pulse on exc_ret_lowest enters the selected state on the next cycle, and that entry wakes by the interrupt rule.
- R3: After an entry by wfi_p, irq_any being high returns mode to 00 on the next cycle. evt_any has no effect.
- R4: After an entry by wfe_p, evt_any being high wakes the block. irq_any wakes it only when ctl_sev_on_pend is 1.
- R5: With deep set and standby-select clear, entry gives mode 10. All five outputs core_clk_en, domain_clk_en, osc_irc_en, osc_hxt_en and pll_en are 0.
- R6: In deep sleep, irq_any and evt_any are ignored. exti_irq and exti_evt wake the block under the same rules as R3 and R4.
- R7: Leaving deep sleep raises sel_irc_clk for exactly one cycle: the first cycle back in mode 00.
- R8: If ctl_lpreg was 1 at deep-sleep entry, mode stays at 10 for WAKE_DLY cycles after the wake is sampled before it returns to 00.
- R9: vreg_sel equals the stored voltage code while pll_locked is 1 and equals VSEL_LOW (0) while it is 0. The stored code resets to VSEL_RST (3).
- R10: A vsel_wr while pll_locked is 1 leaves the stored code unchanged. A vsel_wr while pll_locked is 0 stores vsel_wdata.
- R11: With deep and standby-select both set, entry gives mode 11 with all five clock and oscillator outputs at 0. No wake input leaves that state; only rst_n does.
- R12: If the wake source that qualifies the requested sleep or deep entry is already high when the entry pulse arrives, the entry is cancelled and mode stays 00.
- R13: After reset, mode is 00, all five clock and oscillator outputs are 1, and sel_irc_clk is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset, the only way out of standby |
| ctl_deep | input | 1 | Selects deep sleep or standby instead of sleep |
| ctl_stby | input | 1 | Together with ctl_deep, selects standby |
| ctl_sleep_on_exit | input | 1 | Enter on exit from the lowest-priority handler |
| ctl_sev_on_pend | input | 1 | Lets interrupts also wake an event-entered sleep |
| ctl_lpreg | input | 1 | Regulator low-power in deep sleep; adds the wake delay |
| wfi_p | input | 1 | Wait-for-interrupt pulse |
| wfe_p | input | 1 | Wait-for-event pulse |
| exc_ret_lowest | input | 1 | Return from the lowest-priority handler |
| irq_any | input | 1 | Any interrupt pending (level) |
| evt_any | input | 1 | Any wake event (level) |
| exti_irq | input | 1 | External-line interrupt (level) |
| exti_evt | input | 1 | External-line event (level) |
| pll_locked | input | 1 | PLL running |
| vsel_wr | input | 1 | Write strobe for the voltage code |
| vsel_wdata | input | VW | Voltage code to write |
| core_clk_en | output | 1 | Core clock gate enable |
| domain_clk_en | output | 1 | Core-domain clock gate enable |
| osc_irc_en | output | 1 | Internal RC oscillator enable |
| osc_hxt_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| vreg_sel | output | VW | Regulator voltage code driven |
| sel_irc_clk | output | 1 | One-cycle request to switch the system clock to the RC oscillator |
| mode | output | 2 | Current mode code |

## Verification
The assertions check several rules on every cycle. Standby never changes state. The clock and oscillator enables are low whenever the mode is deep or standby. The selection request never lasts longer than one cycle. A write made while the PLL is locked leaves the stored code unchanged. A qualified wake in sleep returns the block to run on the next cycle. A pending wake cancels an entry. Three properties can be shown only by the bench's scenarios: the exact length of the delayed exit, the way the two entry instructions combine with send-event-on-pending to decide which wake sources count, and the fact that the exit-from-handler path ignores the instruction pulses.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_DEEP  = 3'd2,
        ST_WAKE  = 3'd3,
        ST_STBY  = 3'd4
    } lpm_state_e;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_SLEEP = 2'b01;
    localparam logic [1:0] MODE_DEEP  = 2'b10;
    localparam logic [1:0] MODE_STBY  = 2'b11;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual (
    input  logic in_deep,
    input  logic by_wfe,
    input  logic sev_on_pend,
    input  logic irq_any,
    input  logic evt_any,
    input  logic exti_irq,
    input  logic exti_evt,
    output logic wake
);
    logic irq_src;
    logic evt_src;

    always_comb begin
        irq_src = in_deep ? exti_irq : irq_any;
        evt_src = in_deep ? exti_evt : evt_any;
        if (by_wfe) wake = evt_src | (sev_on_pend & irq_src);
        else        wake = irq_src;
    end
endmodule

// File: rtl/lpm_vreg.sv
module lpm_vreg #(
    parameter int          VW       = 2,
    parameter logic [VW-1:0] VSEL_RST = '1,
    parameter logic [VW-1:0] VSEL_LOW = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_locked,
    input  logic          wr,
    input  logic [VW-1:0] wdata,
    output logic [VW-1:0] vsel_out
);
    logic [VW-1:0] code_d;
    logic [VW-1:0] code_q;

    always_comb begin
        code_d = code_q;
        if (wr && !pll_locked) code_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= VSEL_RST;
        else        code_q <= code_d;
    end

    assign vsel_out = pll_locked ? code_q : VSEL_LOW;

    // R10: a write while the PLL runs leaves the stored code alone
    a_r10_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pll_locked) |=> $stable(code_q));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int            VW       = 2,
    parameter logic [VW-1:0] VSEL_RST = '1,
    parameter logic [VW-1:0] VSEL_LOW = '0,
    parameter int            WAKE_DLY = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_deep,
    input  logic          ctl_stby,
    input  logic          ctl_sleep_on_exit,
    input  logic          ctl_sev_on_pend,
    input  logic          ctl_lpreg,
    input  logic          wfi_p,
    input  logic          wfe_p,
    input  logic          exc_ret_lowest,
    input  logic          irq_any,
    input  logic          evt_any,
    input  logic          exti_irq,
    input  logic          exti_evt,
    input  logic          pll_locked,
    input  logic          vsel_wr,
    input  logic [VW-1:0] vsel_wdata,
    output logic          core_clk_en,
    output logic          domain_clk_en,
    output logic          osc_irc_en,
    output logic          osc_hxt_en,
    output logic          pll_en,
    output logic [VW-1:0] vreg_sel,
    output logic          sel_irc_clk,
    output logic [1:0]    mode
);
    localparam int CW = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY);
    localparam logic [CW-1:0] CNT_LOAD = CW'(WAKE_DLY - 1);

    typedef struct packed {
        lpm_state_e    st;
        logic          by_wfe;
        logic          lpreg;
        logic [CW-1:0] cnt;
        logic          irc;
    } ctrl_t;

    ctrl_t r_d;
    ctrl_t r_q;

    logic entry_go;
    logic entry_wfe;
    logic wake_entry;
    logic wake_cur;

    assign entry_go  = ctl_sleep_on_exit ? exc_ret_lowest : (wfi_p | wfe_p);
    assign entry_wfe = !ctl_sleep_on_exit && wfe_p && !wfi_p;

    lpm_wake_qual u_qual_entry (
        .in_deep     (ctl_deep),
        .by_wfe      (entry_wfe),
        .sev_on_pend (ctl_sev_on_pend),
        .irq_any     (irq_any),
        .evt_any     (evt_any),
        .exti_irq    (exti_irq),
        .exti_evt    (exti_evt),
        .wake        (wake_entry)
    );

    lpm_wake_qual u_qual_cur (
        .in_deep     (r_q.st == ST_DEEP),
        .by_wfe      (r_q.by_wfe),
        .sev_on_pend (ctl_sev_on_pend),
        .irq_any     (irq_any),
        .evt_any     (evt_any),
        .exti_irq    (exti_irq),
        .exti_evt    (exti_evt),
        .wake        (wake_cur)
    );

    lpm_vreg #(
        .VW       (VW),
        .VSEL_RST (VSEL_RST),
        .VSEL_LOW (VSEL_LOW)
    ) u_vreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_locked (pll_locked),
        .wr         (vsel_wr),
        .wdata      (vsel_wdata),
        .vsel_out   (vreg_sel)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irc = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (entry_go) begin
                    if (ctl_deep && ctl_stby) begin
                        r_d.st = ST_STBY;
                    end else if (!wake_entry) begin
                        r_d.st     = ctl_deep ? ST_DEEP : ST_SLEEP;
                        r_d.by_wfe = entry_wfe;
                        r_d.lpreg  = ctl_lpreg;
                    end
                end
            end
            ST_SLEEP: begin
                if (wake_cur) r_d.st = ST_RUN;
            end
            ST_DEEP: begin
                if (wake_cur) begin
                    if (r_q.lpreg) begin
                        r_d.st  = ST_WAKE;
                        r_d.cnt = CNT_LOAD;
                    end else begin
                        r_d.st  = ST_RUN;
                        r_d.irc = 1'b1;
                    end
                end
            end
            ST_WAKE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_RUN;
                    r_d.irc = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_STBY: r_d.st = ST_STBY;
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_RUN;
            r_q.by_wfe <= 1'b0;
            r_q.lpreg  <= 1'b0;
            r_q.cnt    <= '0;
            r_q.irc    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    logic clocks_down;
    assign clocks_down   = (r_q.st == ST_DEEP) || (r_q.st == ST_WAKE) || (r_q.st == ST_STBY);
    assign core_clk_en   = (r_q.st == ST_RUN);
    assign domain_clk_en = !clocks_down;
    assign osc_irc_en    = !clocks_down;
    assign osc_hxt_en    = !clocks_down;
    assign pll_en        = !clocks_down;
    assign sel_irc_clk   = r_q.irc;

    always_comb begin
        unique case (r_q.st)
            ST_RUN:   mode = MODE_RUN;
            ST_SLEEP: mode = MODE_SLEEP;
            ST_STBY:  mode = MODE_STBY;
            default:  mode = MODE_DEEP;
        endcase
    end

    // R11: standby is left only by reset
    a_r11_stby_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STBY) |=> (mode == MODE_STBY));
    // R5: deep and standby keep every clock source off
    a_r5_deep_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |-> !(osc_irc_en || osc_hxt_en || pll_en || domain_clk_en || core_clk_en));
    // R7: the RC select request is a single-cycle pulse
    a_r7_irc_single: assert property (@(posedge clk) disable iff (!rst_n)
        sel_irc_clk |=> !sel_irc_clk);
    // R3: a qualified wake in sleep returns to run next cycle
    a_r3_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && wake_cur) |=> (mode == MODE_RUN));
    // R12: a pending qualifying wake cancels a sleep or deep entry
    a_r12_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && entry_go && wake_entry && !(ctl_deep && ctl_stby)) |=> (mode == MODE_RUN));
    // R9: the low code is driven whenever the PLL is off
    a_r9_low_when_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |-> (vreg_sel == VSEL_LOW));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb_top;
    localparam int CLK_PER = 10;
    localparam int DLY     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_deep = 0, ctl_stby = 0, ctl_sleep_on_exit = 0, ctl_sev_on_pend = 0, ctl_lpreg = 0;
    logic wfi_p = 0, wfe_p = 0, exc_ret_lowest = 0;
    logic irq_any = 0, evt_any = 0, exti_irq = 0, exti_evt = 0;
    logic pll_locked = 0, vsel_wr = 0;
    logic [1:0] vsel_wdata = '0;
    logic core_clk_en, domain_clk_en, osc_irc_en, osc_hxt_en, pll_en, sel_irc_clk;
    logic [1:0] vreg_sel;
    logic [1:0] mode;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    lpm_ctrl #(.VW(2), .VSEL_RST(2'd3), .VSEL_LOW(2'd0), .WAKE_DLY(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_deep(ctl_deep), .ctl_stby(ctl_stby),
        .ctl_sleep_on_exit(ctl_sleep_on_exit), .ctl_sev_on_pend(ctl_sev_on_pend),
        .ctl_lpreg(ctl_lpreg), .wfi_p(wfi_p), .wfe_p(wfe_p), .exc_ret_lowest(exc_ret_lowest),
        .irq_any(irq_any), .evt_any(evt_any), .exti_irq(exti_irq), .exti_evt(exti_evt),
        .pll_locked(pll_locked), .vsel_wr(vsel_wr), .vsel_wdata(vsel_wdata),
        .core_clk_en(core_clk_en), .domain_clk_en(domain_clk_en), .osc_irc_en(osc_irc_en),
        .osc_hxt_en(osc_hxt_en), .pll_en(pll_en), .vreg_sel(vreg_sel),
        .sel_irc_clk(sel_irc_clk), .mode(mode)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic pulse_wfi(); wfi_p = 1; step(); wfi_p = 0; endtask
    task automatic pulse_wfe(); wfe_p = 1; step(); wfe_p = 0; endtask

    task automatic clear_wake(); irq_any = 0; evt_any = 0; exti_irq = 0; exti_evt = 0; endtask

    function automatic int clk_bits();
        return {core_clk_en, domain_clk_en, osc_irc_en, osc_hxt_en, pll_en};
    endfunction

    function automatic bit model_wake(bit deep, bit wfe, bit sev, bit ia, bit ea, bit xi, bit xe);
        bit i, e;
        i = deep ? xi : ia;
        e = deep ? xe : ea;
        return wfe ? (e | (sev & i)) : i;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        step(); step();
        rst_n = 1;
        step();
        // R13 reset state
        check("R13 mode", mode, 0);
        check("R13 clocks", clk_bits(), 31);
        check("R13 irc", sel_irc_clk, 0);
        check("R9 low while pll off", vreg_sel, 0);
        pll_locked = 1; step();
        check("R9 reset code", vreg_sel, 3);

        // R1 / R3 sleep by wfi
        pulse_wfi();
        check("R1 sleep mode", mode, 1);
        check("R1 clocks", clk_bits(), 15);
        evt_any = 1; step();
        check("R3 event ignored", mode, 1);
        evt_any = 0; irq_any = 1; step();
        check("R3 irq wakes", mode, 0);
        clear_wake();

        // R4 sleep by wfe
        pulse_wfe();
        irq_any = 1; step();
        check("R4 irq ignored without sev", mode, 1);
        irq_any = 0; evt_any = 1; step();
        check("R4 event wakes", mode, 0);
        clear_wake();
        ctl_sev_on_pend = 1;
        pulse_wfe();
        irq_any = 1; step();
        check("R4 irq wakes with sev", mode, 0);
        clear_wake(); ctl_sev_on_pend = 0;

        // R2 sleep on exit
        ctl_sleep_on_exit = 1;
        pulse_wfi();
        check("R2 wfi ignored", mode, 0);
        exc_ret_lowest = 1; step(); exc_ret_lowest = 0;
        check("R2 exit entry", mode, 1);
        evt_any = 1; step();
        check("R2 interrupt rule", mode, 1);
        evt_any = 0; irq_any = 1; step();
        check("R2 irq wakes", mode, 0);
        clear_wake(); ctl_sleep_on_exit = 0;

        // R5 / R6 / R7 deep by wfi
        ctl_deep = 1;
        pulse_wfi();
        check("R5 deep mode", mode, 2);
        check("R5 clocks off", clk_bits(), 0);
        irq_any = 1; evt_any = 1; step();
        check("R6 core irq ignored", mode, 2);
        clear_wake(); exti_irq = 1; step();
        check("R6 exti irq wakes", mode, 0);
        check("R7 irc pulse", sel_irc_clk, 1);
        clear_wake(); step();
        check("R7 irc one cycle", sel_irc_clk, 0);

        // R6 deep by wfe
        pulse_wfe();
        exti_irq = 1; step();
        check("R6 exti irq ignored on wfe", mode, 2);
        exti_irq = 0; exti_evt = 1; step();
        check("R6 exti evt wakes", mode, 0);
        clear_wake();

        // R8 delayed exit
        ctl_lpreg = 1;
        pulse_wfi();
        ctl_lpreg = 0;
        exti_irq = 1;
        begin
            int held = 0;
            for (int k = 0; k < DLY; k++) begin
                step(); clear_wake();
                if (mode == 2) held++;
            end
            check("R8 delay cycles in deep", held, DLY);
        end
        step();
        check("R8 run after delay", mode, 0);
        check("R7 irc after delay", sel_irc_clk, 1);
        ctl_deep = 0;

        // R12 cancel
        irq_any = 1;
        pulse_wfi();
        check("R12 sleep cancelled", mode, 0);
        clear_wake(); ctl_deep = 1; exti_evt = 1;
        pulse_wfe();
        check("R12 deep cancelled", mode, 0);
        clear_wake(); ctl_deep = 0;

        // R9 / R10 voltage code
        vsel_wdata = 2'd1; vsel_wr = 1; step(); vsel_wr = 0;
        check("R10 locked write ignored", vreg_sel, 3);
        pll_locked = 0;
        vsel_wdata = 2'd2; vsel_wr = 1; step(); vsel_wr = 0;
        check("R9 low while off", vreg_sel, 0);
        pll_locked = 1; step();
        check("R10 unlocked write stored", vreg_sel, 2);

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit d, w, s, ia, ea, xi, xe, exp_w;
            d = $urandom_range(0, 1); w = $urandom_range(0, 1); s = $urandom_range(0, 1);
            ia = $urandom_range(0, 1); ea = $urandom_range(0, 1);
            xi = $urandom_range(0, 1); xe = $urandom_range(0, 1);
            ctl_deep = d; ctl_sev_on_pend = s;
            if (w) pulse_wfe(); else pulse_wfi();
            check(d ? "R5 random entry" : "R1 random entry", mode, d ? 2 : 1);
            irq_any = ia; evt_any = ea; exti_irq = xi; exti_evt = xe;
            step();
            exp_w = model_wake(d, w, s, ia, ea, xi, xe);
            check(w ? "R4 random wake" : "R3 random wake", mode, exp_w ? 0 : (d ? 2 : 1));
            clear_wake();
            if (!exp_w) begin
                if (d) begin exti_irq = 1; exti_evt = 1; end
                else begin irq_any = 1; evt_any = 1; end
                step(); clear_wake();
                check("R6 random forced wake", mode, 0);
            end
            step();
        end
        ctl_sev_on_pend = 0;

        // R11 standby
        ctl_deep = 1; ctl_stby = 1;
        pulse_wfi();
        check("R11 standby mode", mode, 3);
        check("R11 clocks off", clk_bits(), 0);
        irq_any = 1; evt_any = 1; exti_irq = 1; exti_evt = 1;
        step(); step();
        check("R11 wakes ignored", mode, 3);
        clear_wake(); ctl_deep = 0; ctl_stby = 0;
        rst_n = 0; step(); rst_n = 1; step();
        check("R11 reset exits", mode, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule